// File: doc/BRIEF.md
# Programmable Delay Line Control Core

This block is the digital control core of a five-channel programmable delay chip. A two-wire serial host (I2C, target role) reaches six 8-bit registers. Five of them hold a 6-bit tap code, one per delay channel. Each tap is 0.5 ns, so a code covers 0 to 31.5 ns. Channel 0 is the master line that sits inside the locked loop. Channels 1 to 4 are open-loop replicas and use the same coding. The sixth register is the mode register. It selects the reference frequency, and so the number of elements the master loop spans. It also has two self-clearing command bits: one restarts lock acquisition and one resets all of the control state.

A tap code does not reach the delay line when its data byte arrives. It is applied only at the STOP condition, so a transfer that is cut short never moves a delay. The mode register works differently and takes effect as soon as its byte is accepted. Whenever an applied tap code is larger than the loop length of the selected frequency, a per-channel out-of-range flag is raised. The code is still applied as written. SCL and SDA each pass through a two-flop synchroniser and a persistence filter before any bus event is decoded.

Top module: `dlyctl_top`

## Requirements
- R1: After reset, all tap outputs are 0, the loop length is 64, both strobes and all out-of-range flags are low, and SDA is not driven.
- R2: The target acknowledges only its 7-bit address DEV_ADDR (default 0x2A; the address byte is the address followed by a read/write bit, 0 = write). Any other address is not acknowledged, and the data that follows in that transfer has no effect.
- R3: In a write transfer, the first byte after the address loads the register pointer and each later byte writes the register at the pointer. The pointer then advances by one and wraps from 5 to 0. A pointer byte above 5 selects register 0. Registers 0 to 4 are channels 0 to 4, register 5 is the mode register, and a channel register keeps bits 5:0 and reads bits 7:6 as 0.
- R4: In a read transfer, each byte returns the register at the pointer, and the pointer advances after every byte with the same wrap as in R3.
- R5: A written tap code appears on `tap_sel_o[6*i+5:6*i]` for channel i only after the next STOP. Between the data byte and the STOP, the tap outputs keep their previous values.
- R6: Mode bits 1:0 select the loop length: 0 gives 64, 1 gives 50, 2 gives 32 and 3 gives 25. The new length shows on `loop_len_o` as soon as the byte is accepted, without waiting for STOP. The mode register reads back bits 1:0, with all other bits 0.
- R7: Writing mode bit 6 as 1 produces exactly one single-cycle `dll_init_o` pulse. The bit always reads back as 0.
- R8: Writing mode bit 7 as 1 produces exactly one single-cycle `soft_rst_o` pulse. It clears every stored and applied tap code and the frequency field to 0, overriding the other bits of the same byte. The bit reads back as 0.
- R9: `tap_ovr_o[i]` is high exactly when the applied tap code of channel i is greater than the current loop length. The code is still driven unchanged on the tap output.
- R10: A pulse on SCL or SDA shorter than FILT_LEN system clocks (default 4) is ignored and does not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | Pulls SDA low when high (open drain) |
| tap_sel_o | output | 30 | Applied tap codes, 6 bits per channel, channel 0 in the low bits |
| loop_len_o | output | 7 | Number of elements the master loop spans |
| tap_ovr_o | output | 5 | Per-channel flag: applied code exceeds loop length |
| dll_init_o | output | 1 | One-cycle lock-restart strobe |
| soft_rst_o | output | 1 | One-cycle soft-reset strobe |

## Verification
The two effects that coincide are the loop-length change caused by a mode write and the tap update that happens at STOP. Both can move an out-of-range flag. The bench sweeps tap patterns across all four frequencies in a single burst: pointer 0, then five tap bytes, then the mode byte, with the STOP held back. Before the STOP, it checks that the loop length has already changed while the taps still show their old values. After the STOP, it checks the taps and every flag against a length table and a comparison computed in the bench.

// File: rtl/dlyctl_pkg.sv
package dlyctl_pkg;

  localparam int LEN_W        = 7;
  localparam int MODE_DLL_BIT = 6;
  localparam int MODE_RST_BIT = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADR,
    ST_WDATA,
    ST_ACK_WR,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;

  function automatic logic [LEN_W-1:0] loop_len_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 7'd64;
      2'd1:    return 7'd50;
      2'd2:    return 7'd32;
      default: return 7'd25;
    endcase
  endfunction

endpackage

// File: rtl/dlyctl_line_filt.sv
module dlyctl_line_filt #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic             meta_q, sync_q, clean_q, clean_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // a changed level must persist FILT_LEN samples before it is taken
  always_comb begin
    clean_d = clean_q;
    cnt_d   = '0;
    if (sync_q != clean_q) begin
      if (cnt_q == CNT_W'(FILT_LEN - 1)) clean_d = sync_q;
      else                               cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b1;
      sync_q  <= 1'b1;
      clean_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      meta_q  <= raw_i;
      sync_q  <= meta_q;
      clean_q <= clean_d;
      cnt_q   <= cnt_d;
    end
  end

  assign clean_o = clean_q;

endmodule

// File: rtl/dlyctl_i2c_tgt.sv
module dlyctl_i2c_tgt
  import dlyctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         NUM_REG  = 6,
  parameter int         AW       = $clog2(NUM_REG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          stop_o
);

  tgt_state_e    state_q, state_d;
  logic [3:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic [AW-1:0] ptr_q, ptr_d, ptr_next;
  logic          rw_q, rw_d, first_q, first_d, oe_q, oe_d;
  logic          wr_en_q, wr_en_d, stop_q, stop_d;
  logic [AW-1:0] wr_addr_q, wr_addr_d;
  logic [7:0]    wr_data_q, wr_data_d;
  logic          scl_q, sda_q;
  logic          scl_rise, scl_fall, start_c, stop_c;

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_c   = scl_q & scl_i & ~sda_q & sda_i;
  assign ptr_next = (ptr_q == AW'(NUM_REG - 1)) ? '0 : ptr_q + 1'b1;

  always_comb begin
    state_d   = state_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    ptr_d     = ptr_q;
    rw_d      = rw_q;
    first_d   = first_q;
    oe_d      = oe_q;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr_q;
    wr_data_d = wr_data_q;
    stop_d    = 1'b0;
    if (start_c) begin
      state_d = ST_ADDR;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_c) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      stop_d  = 1'b1;
    end else begin
      case (state_q)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_i};
            bit_d = bit_q + 1'b1;
          end else if (scl_fall && bit_q == 4'd8) begin
            bit_d = '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                oe_d    = 1'b1;
                rw_d    = sh_q[0];
                first_d = 1'b1;
                state_d = ST_ACK_ADR;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              oe_d    = 1'b1;
              state_d = ST_ACK_WR;
              if (first_q) begin
                first_d = 1'b0;
                ptr_d   = (sh_q < 8'(NUM_REG)) ? sh_q[AW-1:0] : '0;
              end else begin
                wr_en_d   = 1'b1;
                wr_addr_d = ptr_q;
                wr_data_d = sh_q;
                ptr_d     = ptr_next;
              end
            end
          end
        end
        ST_ACK_ADR: begin
          if (scl_fall) begin
            bit_d = '0;
            if (rw_q) begin
              sh_d    = rd_data_i;
              oe_d    = ~rd_data_i[7];
              ptr_d   = ptr_next;
              state_d = ST_RDATA;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WDATA;
            end
          end
        end
        ST_ACK_WR: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            bit_d   = '0;
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              oe_d    = 1'b0;
              state_d = ST_RACK;
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              oe_d  = ~sh_q[6];
              bit_d = bit_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise && sda_i) begin
            state_d = ST_IDLE;
          end else if (scl_fall) begin
            sh_d    = rd_data_i;
            oe_d    = ~rd_data_i[7];
            ptr_d   = ptr_next;
            bit_d   = '0;
            state_d = ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      first_q   <= 1'b0;
      oe_q      <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      stop_q    <= 1'b0;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      state_q   <= state_d;
      bit_q     <= bit_d;
      sh_q      <= sh_d;
      ptr_q     <= ptr_d;
      rw_q      <= rw_d;
      first_q   <= first_d;
      oe_q      <= oe_d;
      wr_en_q   <= wr_en_d;
      wr_addr_q <= wr_addr_d;
      wr_data_q <= wr_data_d;
      stop_q    <= stop_d;
      scl_q     <= scl_i;
      sda_q     <= sda_i;
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign rd_addr_o = ptr_q;
  assign stop_o    = stop_q;

endmodule

// File: rtl/dlyctl_regs.sv
module dlyctl_regs
  import dlyctl_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int TAP_W  = 6,
  parameter int AW     = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           wr_addr_i,
  input  logic [7:0]              wr_data_i,
  input  logic                    stop_i,
  input  logic [AW-1:0]           rd_addr_i,
  output logic [7:0]              rd_data_o,
  output logic [NUM_CH*TAP_W-1:0] tap_sel_o,
  output logic [LEN_W-1:0]        loop_len_o,
  output logic [NUM_CH-1:0]       tap_ovr_o,
  output logic                    dll_init_o,
  output logic                    soft_rst_o
);
  localparam int MODE_IDX = NUM_CH;

  logic                    mode_wr, soft_c;
  logic [1:0]              freq_q, freq_d;
  logic                    dll_q, dll_d, srst_q, srst_d;
  logic [NUM_CH*TAP_W-1:0] stg_all;

  assign mode_wr = wr_en_i && (wr_addr_i == AW'(MODE_IDX));
  assign soft_c  = mode_wr && wr_data_i[MODE_RST_BIT];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [TAP_W-1:0] stg_q, stg_d, app_q, app_d;
    logic             hit;

    assign hit = wr_en_i && (wr_addr_i == AW'(c));

    always_comb begin
      stg_d = stg_q;
      app_d = app_q;
      if (soft_c) begin
        stg_d = '0;
        app_d = '0;
      end else begin
        if (hit)    stg_d = wr_data_i[TAP_W-1:0];
        if (stop_i) app_d = stg_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= '0;
        app_q <= '0;
      end else begin
        stg_q <= stg_d;
        app_q <= app_d;
      end
    end

    assign stg_all[c*TAP_W +: TAP_W]   = stg_q;
    assign tap_sel_o[c*TAP_W +: TAP_W] = app_q;
    assign tap_ovr_o[c]                = LEN_W'(app_q) > loop_len_o;
  end

  always_comb begin
    freq_d = freq_q;
    if (soft_c)       freq_d = 2'd0;
    else if (mode_wr) freq_d = wr_data_i[1:0];
    dll_d  = mode_wr && wr_data_i[MODE_DLL_BIT];
    srst_d = soft_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= 2'd0;
      dll_q  <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      freq_q <= freq_d;
      dll_q  <= dll_d;
      srst_q <= srst_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AW'(MODE_IDX)) rd_data_o = {6'd0, freq_q};
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr_i == AW'(c)) rd_data_o = 8'(stg_all[c*TAP_W +: TAP_W]);
    end
  end

  assign loop_len_o = loop_len_of(freq_q);
  assign dll_init_o = dll_q;
  assign soft_rst_o = srst_q;

endmodule

// File: rtl/dlyctl_top.sv
module dlyctl_top
  import dlyctl_pkg::*;
#(
  parameter int         NUM_CH   = 5,
  parameter int         TAP_W    = 6,
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         FILT_LEN = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe_o,
  output logic [NUM_CH*TAP_W-1:0] tap_sel_o,
  output logic [LEN_W-1:0]        loop_len_o,
  output logic [NUM_CH-1:0]       tap_ovr_o,
  output logic                    dll_init_o,
  output logic                    soft_rst_o
);
  localparam int NUM_REG = NUM_CH + 1;
  localparam int AW      = $clog2(NUM_REG);

  logic          rst_meta_q, rst_sync_q;
  logic [1:0]    line_raw, line_clean;
  logic          reg_wr_en, bus_stop;
  logic [AW-1:0] reg_wr_addr, reg_rd_addr;
  logic [7:0]    reg_wr_data, reg_rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign line_raw = {sda_i, scl_i};

  for (genvar l = 0; l < 2; l++) begin : g_line
    dlyctl_line_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk     (clk),
      .rst_n   (rst_sync_q),
      .raw_i   (line_raw[l]),
      .clean_o (line_clean[l])
    );
  end

  dlyctl_i2c_tgt #(
    .DEV_ADDR (DEV_ADDR),
    .NUM_REG  (NUM_REG),
    .AW       (AW)
  ) u_tgt (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .scl_i     (line_clean[0]),
    .sda_i     (line_clean[1]),
    .sda_oe_o  (sda_oe_o),
    .wr_en_o   (reg_wr_en),
    .wr_addr_o (reg_wr_addr),
    .wr_data_o (reg_wr_data),
    .rd_addr_o (reg_rd_addr),
    .rd_data_i (reg_rd_data),
    .stop_o    (bus_stop)
  );

  dlyctl_regs #(
    .NUM_CH (NUM_CH),
    .TAP_W  (TAP_W),
    .AW     (AW)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .wr_en_i    (reg_wr_en),
    .wr_addr_i  (reg_wr_addr),
    .wr_data_i  (reg_wr_data),
    .stop_i     (bus_stop),
    .rd_addr_i  (reg_rd_addr),
    .rd_data_o  (reg_rd_data),
    .tap_sel_o  (tap_sel_o),
    .loop_len_o (loop_len_o),
    .tap_ovr_o  (tap_ovr_o),
    .dll_init_o (dll_init_o),
    .soft_rst_o (soft_rst_o)
  );

endmodule

// File: rtl/dlyctl_chk.sv
module dlyctl_chk #(
  parameter int NUM_CH = 5,
  parameter int TAP_W  = 6,
  parameter int AW     = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_stop,
  input logic                    reg_wr_en,
  input logic [AW-1:0]           reg_wr_addr,
  input logic [7:0]              reg_wr_data,
  input logic [NUM_CH*TAP_W-1:0] tap_sel_o,
  input logic [6:0]              loop_len_o,
  input logic                    dll_init_o,
  input logic                    soft_rst_o
);
  logic soft_wr;
  assign soft_wr = reg_wr_en && (reg_wr_addr == AW'(NUM_CH)) && reg_wr_data[7];

  // R5
  taps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_stop && !soft_wr) |=> $stable(tap_sel_o));

  // R6
  loop_len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_len_o == 7'd64) || (loop_len_o == 7'd50) ||
    (loop_len_o == 7'd32) || (loop_len_o == 7'd25));

  // R7
  dll_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dll_init_o |=> !dll_init_o);

  // R8
  srst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !soft_rst_o);

  // R8
  srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (tap_sel_o == '0) && (loop_len_o == 7'd64));

endmodule

bind dlyctl_top dlyctl_chk #(
  .NUM_CH (NUM_CH),
  .TAP_W  (TAP_W),
  .AW     (AW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_stop    (bus_stop),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_addr (reg_wr_addr),
  .reg_wr_data (reg_wr_data),
  .tap_sel_o   (tap_sel_o),
  .loop_len_o  (loop_len_o),
  .dll_init_o  (dll_init_o),
  .soft_rst_o  (soft_rst_o)
);

// File: tb/test_dlyctl_top.sv
module test_dlyctl_top;
  localparam int NCH = 5;
  localparam int TW  = 6;
  localparam int Q   = 8;
  localparam logic [6:0] ADR = 7'h2A;

  logic            clk, rst_n, scl_drv, sda_drv, sda_oe, sda_bus;
  logic [NCH*TW-1:0] tap_sel;
  logic [6:0]      loop_len;
  logic [NCH-1:0]  tap_ovr;
  logic            dll_init, soft_rst;

  int checks, errors, dll_cnt, srst_cnt, wide_cnt, cyc;
  logic dll_prev, srst_prev;
  logic [TW-1:0] exp_tap [NCH];
  logic [1:0]    exp_freq;

  assign sda_bus = sda_drv & ~sda_oe;

  dlyctl_top i_dlyctl_top (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .tap_sel_o(tap_sel), .loop_len_o(loop_len),
    .tap_ovr_o(tap_ovr), .dll_init_o(dll_init), .soft_rst_o(soft_rst)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (dll_init) dll_cnt <= dll_cnt + 1;
    if (soft_rst) srst_cnt <= srst_cnt + 1;
    if ((dll_init && dll_prev) || (soft_rst && srst_prev)) wide_cnt <= wide_cnt + 1;
    dll_prev  <= dll_init;
    srst_prev <= soft_rst;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [6:0] len_of(input logic [1:0] f);
    case (f)
      2'd0: return 7'd64;
      2'd1: return 7'd50;
      2'd2: return 7'd32;
      default: return 7'd25;
    endcase
  endfunction

  function automatic logic [NCH*TW-1:0] exp_flat();
    logic [NCH*TW-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*TW +: TW] = exp_tap[c];
    return v;
  endfunction

  function automatic logic [NCH-1:0] exp_ovr();
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[c] = {1'b0, exp_tap[c]} > len_of(exp_freq);
    return v;
  endfunction

  task automatic b_start();
    sda_drv = 1'b1; tick(Q); scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b0; tick(Q); scl_drv = 1'b0; tick(Q);
  endtask

  task automatic b_stop();
    sda_drv = 1'b0; tick(Q); scl_drv = 1'b1; tick(Q); sda_drv = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b, input logic glitch);
    sda_drv = b; tick(Q);
    if (glitch) begin scl_drv = 1'b1; tick(1); scl_drv = 1'b0; tick(Q); end
    scl_drv = 1'b1; tick(2*Q); scl_drv = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_drv = 1'b1; tick(Q); scl_drv = 1'b1; tick(Q);
    b = sda_bus; tick(Q); scl_drv = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, input logic glitch, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i], glitch);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(~mack, 1'b0);
  endtask

  initial begin
    logic ack;
    logic [7:0] rb;
    logic [5:0] t;
    checks = 0; errors = 0; dll_cnt = 0; srst_cnt = 0; wide_cnt = 0; cyc = 0;
    dll_prev = 0; srst_prev = 0;
    scl_drv = 1'b1; sda_drv = 1'b1; rst_n = 1'b0;
    for (int c = 0; c < NCH; c++) exp_tap[c] = '0;
    exp_freq = 2'd0;
    tick(5); rst_n = 1'b1; tick(10);

    // R1 reset state
    check("R1 taps", 32'(tap_sel), 0);
    check("R1 loop", 32'(loop_len), 64);
    check("R1 ovr/strobes/sda", {tap_ovr, dll_init, soft_rst, sda_oe}, 0);

    // R5 R6 R9 sweep: burst of taps and mode, STOP held back
    for (int f = 0; f < 4; f++) begin
      for (int k = 0; k < 8; k++) begin
        b_start();
        wr_byte({ADR, 1'b0}, 1'b0, ack);
        check("R2 ack", 32'(ack), 1);
        wr_byte(8'd0, 1'b0, ack);
        for (int c = 0; c < NCH; c++) begin
          t = 6'((k*8 + c*11 + f*5) % 64);
          wr_byte({2'b11, t}, 1'b0, ack);
        end
        wr_byte(8'(f), 1'b0, ack);
        tick(20);
        check("R5 taps held before stop", 32'(tap_sel), 32'(exp_flat()));
        check("R6 loop before stop", 32'(loop_len), 32'(len_of(2'(f))));
        b_stop(); tick(20);
        exp_freq = 2'(f);
        for (int c = 0; c < NCH; c++) exp_tap[c] = 6'((k*8 + c*11 + f*5) % 64);
        check("R5 taps after stop", 32'(tap_sel), 32'(exp_flat()));
        check("R9 ovr", 32'(tap_ovr), 32'(exp_ovr()));
      end
    end

    // R4 read from pointer 3 with wrap past mode register
    b_start(); wr_byte({ADR, 1'b0}, 1'b0, ack); wr_byte(8'd3, 1'b0, ack);
    b_start(); wr_byte({ADR, 1'b1}, 1'b0, ack);
    rd_byte(1'b1, rb); check("R4 ch3", 32'(rb), 32'(exp_tap[3]));
    rd_byte(1'b1, rb); check("R4 ch4", 32'(rb), 32'(exp_tap[4]));
    rd_byte(1'b1, rb); check("R4 R6 mode readback", 32'(rb), 32'(exp_freq));
    rd_byte(1'b0, rb); check("R4 wrap ch0", 32'(rb), 32'(exp_tap[0]));
    b_stop(); tick(10);

    // R3 write wrap from 5 to 0; pointer above 5 selects 0
    b_start(); wr_byte({ADR, 1'b0}, 1'b0, ack); wr_byte(8'd4, 1'b0, ack);
    wr_byte(8'h15, 1'b0, ack); wr_byte(8'h01, 1'b0, ack); wr_byte(8'h2C, 1'b0, ack);
    b_stop(); tick(20);
    exp_tap[4] = 6'h15; exp_tap[0] = 6'h2C; exp_freq = 2'd1;
    check("R3 wrap write", 32'(tap_sel), 32'(exp_flat()));
    b_start(); wr_byte({ADR, 1'b0}, 1'b0, ack); wr_byte(8'd7, 1'b0, ack);
    b_start(); wr_byte({ADR, 1'b1}, 1'b0, ack); rd_byte(1'b0, rb); b_stop(); tick(10);
    check("R3 high pointer reads reg0", 32'(rb), 32'h2C);

    // R2 foreign address ignored
    b_start(); wr_byte({ADR ^ 7'h01, 1'b0}, 1'b0, ack);
    check("R2 nack", 32'(ack), 0);
    wr_byte(8'd0, 1'b0, ack); wr_byte(8'h3F, 1'b0, ack);
    b_stop(); tick(20);
    check("R2 no effect", 32'(tap_sel), 32'(exp_flat()));

    // R10 glitches on SCL during a write
    b_start(); wr_byte({ADR, 1'b0}, 1'b1, ack); wr_byte(8'd2, 1'b1, ack);
    wr_byte(8'h27, 1'b1, ack); b_stop(); tick(20);
    exp_tap[2] = 6'h27;
    check("R10 glitch ignored", 32'(tap_sel), 32'(exp_flat()));

    // R7 lock restart strobe
    b_start(); wr_byte({ADR, 1'b0}, 1'b0, ack); wr_byte(8'd5, 1'b0, ack);
    wr_byte(8'h42, 1'b0, ack); b_stop(); tick(20);
    exp_freq = 2'd2;
    check("R7 dll pulses", 32'(dll_cnt), 1);
    check("R7 loop", 32'(loop_len), 32);
    b_start(); wr_byte({ADR, 1'b0}, 1'b0, ack); wr_byte(8'd5, 1'b0, ack);
    b_start(); wr_byte({ADR, 1'b1}, 1'b0, ack); rd_byte(1'b0, rb); b_stop(); tick(10);
    check("R7 bit reads 0", 32'(rb), 32'h02);

    // R8 soft reset overrides frequency bits
    b_start(); wr_byte({ADR, 1'b0}, 1'b0, ack); wr_byte(8'd5, 1'b0, ack);
    wr_byte(8'h83, 1'b0, ack); tick(20);
    check("R8 srst pulse", 32'(srst_cnt), 1);
    check("R8 taps cleared", 32'(tap_sel), 0);
    check("R8 loop", 32'(loop_len), 64);
    b_stop(); tick(20);
    for (int c = 0; c < NCH; c++) exp_tap[c] = '0;
    exp_freq = 2'd0;
    b_start(); wr_byte({ADR, 1'b0}, 1'b0, ack); wr_byte(8'd4, 1'b0, ack);
    b_start(); wr_byte({ADR, 1'b1}, 1'b0, ack);
    rd_byte(1'b1, rb); check("R8 ch4 cleared", 32'(rb), 0);
    rd_byte(1'b0, rb); check("R8 mode reads 0", 32'(rb), 0);
    b_stop(); tick(20);
    check("R8 staged cleared", 32'(tap_sel), 0);
    check("R7 R8 single cycle", 32'(wide_cnt), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected<190000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule